// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Controller

This block sits between user logic and an external 16-bit pseudo-SRAM with a DRAM core, organised as 8M words. User logic posts a single-cycle request: a strobe, a read/write select, a 23-bit word address, 16-bit write data and two byte-enable bits. The controller turns it into one asynchronous bus cycle on the active-low memory strobes. When the cycle ends, it returns a one-cycle done pulse, and for a read it returns the captured word alongside that pulse.

The device enters its asynchronous mode at power-up, and the controller keeps it there. It holds the memory clock, the address-valid strobe and the configuration-register enable low for good, so every access reaches the array. The device's wait output is ignored. Access time is met by counting system clock cycles, and the read and write lengths are parameters. After every access there is one recovery cycle with chip enable high, and the shared data bus is driven only while write enable is low.

Top module: `psram_async_ctrl`

## Requirements
- R1: During and directly after reset, mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_ub_n_o and mem_lb_n_o are 1, busy_o and done_o are 0, and the controller does not drive mem_dq_io.
- R2: mem_clk_o, mem_adv_n_o and mem_cre_o are 0 at all times.
- R3: A read request (req_i=1, req_write_i=0) accepted at a clock edge opens a read cycle in the following cycle. The cycle lasts RD_CYCLES cycles with mem_ce_n_o=0, mem_oe_n_o=0, mem_ub_n_o=0, mem_lb_n_o=0 and mem_we_n_o=1, and mem_addr_o equals the requested address.
- R4: The read word is sampled from mem_dq_io at the edge that ends the last read cycle. It appears on rdata_o in the single cycle that done_o is 1.
- R5: A write request (req_write_i=1) opens a write cycle of WR_CYCLES cycles with mem_ce_n_o=0, mem_we_n_o=0 and mem_oe_n_o=1. Byte-enable bit 0 controls the lower lane, bits 7:0 (mem_lb_n_o = NOT req_be_i[0]), and bit 1 controls the upper lane, bits 15:8 (mem_ub_n_o = NOT req_be_i[1]).
- R6: The controller drives mem_dq_io with the request's write data only while mem_we_n_o is 0. Every read cycle is preceded by at least one cycle in which the bus is released.
- R7: Each access is followed by exactly one recovery cycle with mem_ce_n_o=1. done_o is 1 in that cycle, and a new access can start no earlier than the next cycle.
- R8: busy_o is 1 from the cycle after acceptance through the done cycle, and 0 otherwise. A request made while busy_o is 1 is ignored and produces no bus cycle.
- R9: The level of mem_wait_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 23 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read word, valid with done_o |
| mem_clk_o | output | 1 | Memory clock, held low |
| mem_adv_n_o | output | 1 | Address-valid strobe, held low |
| mem_cre_o | output | 1 | Configuration-register enable, held low |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_ub_n_o | output | 1 | Upper byte enable, active low |
| mem_lb_n_o | output | 1 | Lower byte enable, active low |
| mem_addr_o | output | 23 | Memory word address |
| mem_dq_io | inout | 16 | Bidirectional data bus |
| mem_wait_i | input | 1 | Device wait output, ignored |

## Verification
The bench's memory model drives a junk word until the last read cycle. A controller that samples one cycle early therefore returns junk instead of stored data. Partial writes with byte-enable patterns 01, 10 and 00 are read back; swapped lanes or a write that ignores the enables would show up as a wrong merged word. Requests are also held high back-to-back and pulsed in the middle of an access. A design that skipped the recovery cycle, or that accepted a request while busy, would strobe chip enable at a cycle the reference model does not expect. Toggling the wait input at random exposes any path through which it leaks into the outputs.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RECOV = 2'd3
    } psram_state_e;

    function automatic int unsigned count_width(input int unsigned max_count);
        return (max_count < 2) ? 1 : $clog2(max_count);
    endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 23,
    parameter int unsigned BE_W      = 2,
    parameter int unsigned RD_CYCLES = 4,
    parameter int unsigned WR_CYCLES = 4,
    parameter int unsigned CW        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic              timer_expired_i,
    output logic              timer_load_o,
    output logic [CW-1:0]     timer_val_o,
    output logic              accept_o,
    output logic              capture_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [BE_W-1:0]   be_n_o,
    output logic              dq_oe_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYCLES - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYCLES - 1);

    typedef struct packed {
        psram_state_e      st;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [BE_W-1:0]   be_n;
        logic              dq_oe;
        logic              done;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        timer_load_o = 1'b0;
        timer_val_o  = '0;
        accept_o     = 1'b0;
        capture_o    = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o     = 1'b1;
                    timer_load_o = 1'b1;
                    seq_d.addr   = req_addr_i;
                    seq_d.ce_n   = 1'b0;
                    if (req_write_i) begin
                        seq_d.st    = ST_WRITE;
                        timer_val_o = WR_LOAD;
                        seq_d.we_n  = 1'b0;
                        seq_d.oe_n  = 1'b1;
                        seq_d.be_n  = ~req_be_i;
                        seq_d.dq_oe = 1'b1;
                    end else begin
                        seq_d.st    = ST_READ;
                        timer_val_o = RD_LOAD;
                        seq_d.we_n  = 1'b1;
                        seq_d.oe_n  = 1'b0;
                        seq_d.be_n  = '0;
                        seq_d.dq_oe = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (timer_expired_i) begin
                    capture_o  = 1'b1;
                    seq_d.st   = ST_RECOV;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    seq_d.be_n = '1;
                    seq_d.done = 1'b1;
                end
            end
            ST_WRITE: begin
                if (timer_expired_i) begin
                    seq_d.st    = ST_RECOV;
                    seq_d.ce_n  = 1'b1;
                    seq_d.we_n  = 1'b1;
                    seq_d.be_n  = '1;
                    seq_d.dq_oe = 1'b0;
                    seq_d.done  = 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_IDLE;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.be_n  <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.st != ST_IDLE);
    assign done_o  = seq_q.done;
    assign ce_n_o  = seq_q.ce_n;
    assign oe_n_o  = seq_q.oe_n;
    assign we_n_o  = seq_q.we_n;
    assign be_n_o  = seq_q.be_n;
    assign dq_oe_o = seq_q.dq_oe;
    assign addr_o  = seq_q.addr;

    // R3: read strobes always appear together
    a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.oe_n |-> (!seq_q.ce_n && seq_q.we_n && seq_q.be_n == '0));

    // R5: a write never has output enable asserted
    a_r5_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.we_n |-> (!seq_q.ce_n && seq_q.oe_n));

    // R6: the bus is driven only inside a write
    a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.dq_oe |-> !seq_q.we_n);

    // R6: the bus was released in the cycle before a read begins
    a_r6_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.oe_n) |-> !$past(seq_q.dq_oe));

    // R7: completion coincides with chip enable high
    a_r7_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> seq_q.ce_n);

    // R4: done lasts a single cycle
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R8: busy cannot drop before done
    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !seq_q.done) |=> busy_o);

endmodule

// File: rtl/psram_dq_path.sv
module psram_dq_path #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dpath_t;

    dpath_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept_i) begin
            dp_d.wdata = wdata_i;
        end
        if (capture_i) begin
            dp_d.rdata = bus_in_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign wdata_o = dp_q.wdata;
    assign rdata_o = dp_q.rdata;

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 23,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned RD_CYCLES = 4,
    parameter int unsigned WR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [1:0]        req_be_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mem_clk_o,
    output logic              mem_adv_n_o,
    output logic              mem_cre_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic              mem_ub_n_o,
    output logic              mem_lb_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    inout  wire  [DATA_W-1:0] mem_dq_io,
    input  logic              mem_wait_i
);
    localparam int unsigned BE_W   = 2;
    localparam int unsigned MAX_CY = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int unsigned CW     = count_width(MAX_CY);

    logic              timer_load;
    logic [CW-1:0]     timer_val;
    logic              timer_expired;
    logic              accept;
    logic              capture;
    logic [BE_W-1:0]   be_n;
    logic              dq_oe;
    logic [DATA_W-1:0] wdata_q;
    logic              unused_wait;

    assign unused_wait = mem_wait_i;

    psram_cycle_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .expired_o  (timer_expired)
    );

    psram_seq #(
        .ADDR_W    (ADDR_W),
        .BE_W      (BE_W),
        .RD_CYCLES (RD_CYCLES),
        .WR_CYCLES (WR_CYCLES),
        .CW        (CW)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_i           (req_i),
        .req_write_i     (req_write_i),
        .req_addr_i      (req_addr_i),
        .req_be_i        (req_be_i),
        .timer_expired_i (timer_expired),
        .timer_load_o    (timer_load),
        .timer_val_o     (timer_val),
        .accept_o        (accept),
        .capture_o       (capture),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .ce_n_o          (mem_ce_n_o),
        .oe_n_o          (mem_oe_n_o),
        .we_n_o          (mem_we_n_o),
        .be_n_o          (be_n),
        .dq_oe_o         (dq_oe),
        .addr_o          (mem_addr_o)
    );

    psram_dq_path #(.DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .wdata_i   (req_wdata_i),
        .capture_i (capture),
        .bus_in_i  (mem_dq_io),
        .wdata_o   (wdata_q),
        .rdata_o   (rdata_o)
    );

    assign mem_lb_n_o  = be_n[0];
    assign mem_ub_n_o  = be_n[1];
    assign mem_clk_o   = 1'b0;
    assign mem_adv_n_o = 1'b0;
    assign mem_cre_o   = 1'b0;
    assign mem_dq_io   = dq_oe ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: tb/psram_async_ctrl_tb.sv
`timescale 1ns/1ps
module psram_async_ctrl_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int RD = 4;
    localparam int WR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        mem_wait = 1'b0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        m_clk, m_adv_n, m_cre, m_ce_n, m_oe_n, m_we_n, m_ub_n, m_lb_n;
    logic [22:0] m_addr;
    wire  [15:0] dq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_async_ctrl #(.RD_CYCLES(RD), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_write_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .mem_clk_o(m_clk), .mem_adv_n_o(m_adv_n), .mem_cre_o(m_cre),
        .mem_ce_n_o(m_ce_n), .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n),
        .mem_ub_n_o(m_ub_n), .mem_lb_n_o(m_lb_n), .mem_addr_o(m_addr),
        .mem_dq_io(dq), .mem_wait_i(mem_wait)
    );

    // behavioural device: junk until the access time has elapsed
    logic [15:0] dev_mem [int];
    logic [15:0] gold_mem [int];
    int          dev_cnt = 0;
    logic        dev_drv;
    logic [15:0] dev_val;

    function automatic logic [15:0] dflt(input logic [22:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    always @(posedge clk) dev_cnt <= m_ce_n ? 0 : dev_cnt + 1;

    assign dev_drv = !m_ce_n && !m_oe_n && m_we_n;
    always_comb begin
        if (dev_cnt >= RD - 1)
            dev_val = dev_mem.exists(int'(m_addr)) ? dev_mem[int'(m_addr)] : dflt(m_addr);
        else
            dev_val = 16'hBAD0;
    end
    assign dq = dev_drv ? dev_val : 16'hzzzz;

    always @(negedge clk) begin
        if (rst_n && !m_ce_n && !m_we_n) begin
            logic [15:0] cur;
            cur = dev_mem.exists(int'(m_addr)) ? dev_mem[int'(m_addr)] : dflt(m_addr);
            if (!m_lb_n) cur[7:0] = dq[7:0];
            if (!m_ub_n) cur[15:8] = dq[15:8];
            dev_mem[int'(m_addr)] = cur;
        end
        mem_wait = 1'($urandom);
    end

    // reference model
    int          e_left = 0;
    bit          e_rec = 0;
    bit          e_wr = 0;
    logic [22:0] e_addr = '0;
    logic [15:0] e_wdata = '0;
    logic [1:0]  e_be = '0;
    logic [15:0] e_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_left = 0; e_rec = 0;
        end else if (e_left > 0) begin
            e_left = e_left - 1;
            if (e_left == 0) begin
                e_rec = 1;
                if (!e_wr)
                    e_rdata = gold_mem.exists(int'(e_addr)) ? gold_mem[int'(e_addr)] : dflt(e_addr);
            end
        end else if (e_rec) begin
            e_rec = 0;
        end else if (req) begin
            e_wr = req_wr; e_addr = req_addr; e_wdata = req_wdata; e_be = req_be;
            e_left = req_wr ? WR : RD;
            if (req_wr) begin
                logic [15:0] g;
                g = gold_mem.exists(int'(req_addr)) ? gold_mem[int'(req_addr)] : dflt(req_addr);
                if (req_be[0]) g[7:0] = req_wdata[7:0];
                if (req_be[1]) g[15:8] = req_wdata[15:8];
                gold_mem[int'(req_addr)] = g;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit act;
            act = (e_left > 0);
            chk(rst_n ? "R7 ce_n" : "R1 ce_n", 32'(m_ce_n), 32'(!act));
            chk("R3 oe_n", 32'(m_oe_n), 32'(!(act && !e_wr)));
            chk("R5 we_n", 32'(m_we_n), 32'(!(act && e_wr)));
            chk("R5 lb_n", 32'(m_lb_n), 32'(act ? (e_wr ? !e_be[0] : 1'b0) : 1'b1));
            chk("R5 ub_n", 32'(m_ub_n), 32'(act ? (e_wr ? !e_be[1] : 1'b0) : 1'b1));
            chk("R8 busy", 32'(busy), 32'(act || e_rec));
            chk("R4 done", 32'(done), 32'(e_rec));
            chk("R2 parked pins", {29'd0, m_clk, m_adv_n, m_cre}, 32'd0);
            if (act) chk("R3 addr", 32'(m_addr), 32'(e_addr));
            if (act && e_wr) chk("R6 write data on bus", 32'(dq), 32'(e_wdata));
            if (e_rec && !e_wr) chk("R4 rdata", 32'(rdata), 32'(e_rdata));
        end
    end

    task automatic idle_wait();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!busy && e_left == 0 && !e_rec) break;
        end
    endtask

    task automatic op(input bit wr, input logic [22:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req = 0;
        idle_wait();
    endtask

    task automatic read_expect(input logic [22:0] a, input logic [15:0] exp, input string tag);
        op(0, a, 16'h0, 2'b00);
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 idle busy", 32'(busy), 32'd0);
        chk("R1 idle strobes", {27'd0, m_ce_n, m_oe_n, m_we_n, m_ub_n, m_lb_n}, 32'h1F);

        op(1, 23'h000010, 16'h1234, 2'b11);
        read_expect(23'h000010, 16'h1234, "R4 full write readback");
        op(1, 23'h000010, 16'hABCD, 2'b01);
        read_expect(23'h000010, 16'h12CD, "R5 lower lane write");
        op(1, 23'h000010, 16'h5600, 2'b10);
        read_expect(23'h000010, 16'h56CD, "R5 upper lane write");
        op(1, 23'h000010, 16'hFFFF, 2'b00);
        read_expect(23'h000010, 16'h56CD, "R5 no-lane write");
        read_expect(23'h7FFFFF, dflt(23'h7FFFFF), "R3 top address read");

        // R8: request pulsed mid-access is ignored
        @(negedge clk);
        req = 1; req_wr = 0; req_addr = 23'h000020;
        @(negedge clk);
        req = 1; req_wr = 1; req_addr = 23'h000333; req_wdata = 16'h7777; req_be = 2'b11;
        @(negedge clk);
        req = 0;
        idle_wait();
        read_expect(23'h000333, dflt(23'h000333), "R8 busy request ignored");

        // R7: back-to-back requests held high
        @(negedge clk);
        req = 1; req_wr = 1; req_addr = 23'h000044; req_wdata = 16'hC0DE; req_be = 2'b11;
        for (int i = 0; i < 2*(WR+1) + 1; i++) @(negedge clk);
        req_wr = 0;
        for (int i = 0; i < 2*(RD+1); i++) @(negedge clk);
        req = 0;
        idle_wait();
        read_expect(23'h000044, 16'hC0DE, "R7 back-to-back write");

        // R9: wait pin toggled throughout, outputs already compared every cycle
        chk("R9 idle with wait activity", 32'(busy), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule